// File: doc/BRIEF.md
# Runtime-Configurable UART Transceiver

This block is a full-duplex asynchronous serial port. It turns bytes offered on a valid/ready transmit stream into serial frames on `tx_o`. It also turns frames arriving on `rx_i` into bytes on a receive stream. Every frame has one low start bit and eight data bits, sent least significant bit first. An optional parity bit follows, then one or two high stop bits. The bit rate comes from a fixed system clock frequency `CLK_HZ`. Each bit is divided into sixteen sample ticks.

The frame format can be changed at run time with a one-cycle configuration write. The format covers the rate (one of seven), the parity mode and the stop length. A write is parked as pending and only takes effect once both directions are idle. Settings stay in force until the next hardware reset. A reset brings back 9600 bit/s, no parity and one stop bit.

The system-clock mode input `hf_mode` is high when the chip runs from a clock that cannot produce usable bit timing. While it is high, the transceiver is switched off. The line stays high, no byte is accepted and incoming traffic is ignored.

Top module: `uart_rt`

## Requirements
- R1: After reset, `tx_o` is high, `tx_ready` is high, `rx_valid` and both error flags are low. The active format is 9600 bit/s, no parity, one stop bit.
- R2: A transmitted frame is one low start bit, then data bits 0 to 7, then the parity bit if enabled, then the stop bits. `tx_ready` stays low from acceptance to the end of the last stop bit, and the idle line is high.
- R3: Rate select code 0 to 6 picks 9600, 19200, 38400, 57600, 115200, 230400 and 460800 bit/s. One bit lasts `CLK_HZ`/rate clock cycles, which is 16 ticks of `CLK_HZ`/(16·rate).
- R4: Parity code 0 means none, 1 even (the number of ones in data plus parity is even) and 2 odd. Code 3 rejects the whole write.
- R5: With `cfg_stop2` = 1 the transmitter sends two stop bits, and with 0 it sends one.
- R6: A write with rate code 7 is rejected entirely, and the current format stays in force.
- R7: An accepted write takes effect only when both transmitter and receiver are idle. Until then `tx_ready` is low, and a frame already in progress finishes in the old format.
- R8: The receiver takes each bit as the majority of samples 7, 8 and 9 of its 16 ticks. A start pulse whose majority reads high, i.e. one shorter than half a bit, is dropped as a glitch.
- R9: A parity mismatch sets `err_parity` and a low stop bit sets `err_frame`. Both flags stay set until reset, and the byte is still delivered.
- R10: While `hf_mode` is high, `tx_o` is high, `tx_ready` is low and activity on `rx_i` delivers nothing.
- R11: A received byte stays on `rx_data` with `rx_valid` high until a cycle with `rx_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of frequency `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low reset |
| hf_mode | input | 1 | High-frequency clock mode; switches the transceiver off |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter takes the byte this cycle |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Consumer takes the received byte |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_baud | input | 3 | Rate select code |
| cfg_par | input | 2 | Parity code |
| cfg_stop2 | input | 1 | Two stop bits when high |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky stop-bit error |

## Verification
Two things can collide: a configuration write and a frame that is still in flight, since the write may land mid-frame or in the very cycle the line goes idle. The bench starts a slow frame and writes a fast rate three bit times into it. It then decodes the running frame at the old bit time, checks that `tx_ready` stays low, and decodes the next frame at the new bit time. Sticky errors meeting later good frames are judged the same way: the flags must survive while the byte still arrives intact.

// File: rtl/uart_rt_pkg.sv
package uart_rt_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2
  } par_e;

  typedef struct packed {
    logic [2:0] baud;
    par_e       par;
    logic       stop2;
  } cfg_t;

  typedef enum logic [2:0] {
    TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
  } tx_st_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_st_e;

  localparam int unsigned OVS      = 16;
  localparam int unsigned MIN_RATE = 9600;
  localparam logic [2:0]  BAUD_BAD = 3'd7;

  function automatic int unsigned rate_of(input logic [2:0] sel);
    case (sel)
      3'd0:    return 9600;
      3'd1:    return 19200;
      3'd2:    return 38400;
      3'd3:    return 57600;
      3'd4:    return 115200;
      3'd5:    return 230400;
      default: return 460800;
    endcase
  endfunction

  function automatic int unsigned div_of(input logic [2:0] sel, input int unsigned clk_hz);
    return clk_hz / (OVS * rate_of(sel));
  endfunction

endpackage

// File: rtl/uart_rt_baud.sv
module uart_rt_baud #(
  parameter int unsigned CLK_HZ = 7372800,
  parameter int unsigned DW     = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [DW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim   = DW'(uart_rt_pkg::div_of(sel, CLK_HZ) - 1);
    tick  = run && (cnt_q == lim);
    cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart_rt_tx.sv
module uart_rt_tx
  import uart_rt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       hold,
  input  cfg_t       cfg,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       line,
  output logic       idle
);
  tx_st_e     st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic       pb_q, pb_d, sec_q, sec_d, line_q, line_d;

  assign idle     = (st_q == TX_IDLE);
  assign tx_ready = en && idle && !hold;
  assign line     = line_q | ~en;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; bit_d = bit_q; sh_d = sh_q;
    pb_d = pb_q; sec_d = sec_q; line_d = line_q;
    if (!en) begin
      st_d   = TX_IDLE;
      line_d = 1'b1;
      cnt_d  = '0;
    end else if (st_q == TX_IDLE) begin
      line_d = 1'b1;
      if (tx_valid && !hold) begin
        st_d   = TX_START;
        line_d = 1'b0;
        sh_d   = tx_data;
        cnt_d  = '0;
        bit_d  = '0;
        sec_d  = 1'b0;
        pb_d   = (^tx_data) ^ (cfg.par == PAR_ODD);
      end
    end else if (tick) begin
      if (cnt_q != 4'hF) begin
        cnt_d = cnt_q + 4'd1;
      end else begin
        cnt_d = '0;
        unique case (st_q)
          TX_START: begin
            st_d   = TX_DATA;
            line_d = sh_q[0];
          end
          TX_DATA: begin
            if (bit_q == 3'd7) begin
              if (cfg.par != PAR_NONE) begin
                st_d   = TX_PAR;
                line_d = pb_q;
              end else begin
                st_d   = TX_STOP;
                line_d = 1'b1;
              end
            end else begin
              bit_d  = bit_q + 3'd1;
              sh_d   = {1'b0, sh_q[7:1]};
              line_d = sh_q[1];
            end
          end
          TX_PAR: begin
            st_d   = TX_STOP;
            line_d = 1'b1;
          end
          TX_STOP: begin
            if (cfg.stop2 && !sec_q) sec_d = 1'b1;
            else                     st_d  = TX_IDLE;
          end
          default: st_d = TX_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TX_IDLE; cnt_q <= '0; bit_q <= '0; sh_q <= '0;
      pb_q <= 1'b0; sec_q <= 1'b0; line_q <= 1'b1;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; bit_q <= bit_d; sh_q <= sh_d;
      pb_q <= pb_d; sec_q <= sec_d; line_q <= line_d;
    end
  end
endmodule

// File: rtl/uart_rt_rx.sv
module uart_rt_rx
  import uart_rt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  cfg_t       cfg,
  input  logic       rx_i,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       idle,
  output logic       err_parity,
  output logic       err_frame
);
  rx_st_e     st_q, st_d;
  logic [1:0] sy_q;
  logic       rx_s;
  logic [3:0] cnt_q, cnt_d;
  logic [2:0] bit_q, bit_d;
  logic [1:0] ones_q, ones_d, sum;
  logic       vote;
  logic [7:0] sh_q, sh_d, dat_q, dat_d;
  logic       val_q, val_d, pe_q, pe_d, fe_q, fe_d;

  assign rx_s       = sy_q[1];
  assign idle       = (st_q == RX_IDLE);
  assign rx_data    = dat_q;
  assign rx_valid   = val_q;
  assign err_parity = pe_q;
  assign err_frame  = fe_q;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; bit_d = bit_q; ones_d = ones_q;
    sh_d = sh_q; dat_d = dat_q; pe_d = pe_q; fe_d = fe_q;
    val_d = val_q && !rx_ready;
    sum   = ones_q + {1'b0, rx_s};
    vote  = sum[1];
    if (!en) begin
      st_d   = RX_IDLE;
      cnt_d  = '0;
      ones_d = '0;
    end else if (st_q == RX_IDLE) begin
      if (!rx_s) begin
        st_d   = RX_START;
        cnt_d  = '0;
        ones_d = '0;
      end
    end else if (tick) begin
      cnt_d = cnt_q + 4'd1;
      if (cnt_q >= 4'd7 && cnt_q <= 4'd8) ones_d = sum;
      if (cnt_q == 4'd9) begin
        ones_d = '0;
        unique case (st_q)
          RX_START: if (vote) st_d = RX_IDLE;
          RX_DATA:  sh_d = {vote, sh_q[7:1]};
          RX_PAR:   if (vote != ((^sh_q) ^ (cfg.par == PAR_ODD))) pe_d = 1'b1;
          RX_STOP: begin
            if (!vote) fe_d = 1'b1;
            dat_d = sh_q;
            val_d = 1'b1;
            st_d  = RX_IDLE;
          end
          default: st_d = RX_IDLE;
        endcase
      end
      if (cnt_q == 4'hF) begin
        cnt_d = '0;
        unique case (st_q)
          RX_START: begin
            st_d  = RX_DATA;
            bit_d = '0;
          end
          RX_DATA: begin
            if (bit_q == 3'd7) st_d = (cfg.par != PAR_NONE) ? RX_PAR : RX_STOP;
            else               bit_d = bit_q + 3'd1;
          end
          RX_PAR:  st_d = RX_STOP;
          default: st_d = RX_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_q <= 2'b11; st_q <= RX_IDLE; cnt_q <= '0; bit_q <= '0; ones_q <= '0;
      sh_q <= '0; dat_q <= '0; val_q <= 1'b0; pe_q <= 1'b0; fe_q <= 1'b0;
    end else begin
      sy_q <= {sy_q[0], rx_i}; st_q <= st_d; cnt_q <= cnt_d; bit_q <= bit_d;
      ones_q <= ones_d; sh_q <= sh_d; dat_q <= dat_d; val_q <= val_d;
      pe_q <= pe_d; fe_q <= fe_d;
    end
  end
endmodule

// File: rtl/uart_rt.sv
module uart_rt
  import uart_rt_pkg::*;
#(
  parameter int unsigned CLK_HZ = 7372800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hf_mode,
  input  logic       rx_i,
  output logic       tx_o,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  input  logic       cfg_wr,
  input  logic [2:0] cfg_baud,
  input  logic [1:0] cfg_par,
  input  logic       cfg_stop2,
  output logic       err_parity,
  output logic       err_frame
);
  localparam int unsigned MAX_DIV = CLK_HZ / (OVS * MIN_RATE);
  localparam int unsigned DW      = $clog2(MAX_DIV) + 1;

  logic [1:0] rs_q;
  logic       rst_i_n, en, tick, tx_idle, rx_idle, wr_ok, apply;
  cfg_t       act_q, act_d, pend_q, pend_d;
  logic       pv_q, pv_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];
  assign en      = ~hf_mode;

  assign wr_ok = cfg_wr && (cfg_baud != BAUD_BAD) && (cfg_par != 2'd3);
  assign apply = pv_q && tx_idle && rx_idle;

  always_comb begin
    act_d  = act_q;
    pend_d = pend_q;
    if (apply) act_d = pend_q;
    if (wr_ok) begin
      pend_d.baud  = cfg_baud;
      pend_d.par   = par_e'(cfg_par);
      pend_d.stop2 = cfg_stop2;
    end
    pv_d = wr_ok | (pv_q & ~apply);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      act_q  <= '{baud: 3'd0, par: PAR_NONE, stop2: 1'b0};
      pend_q <= '{baud: 3'd0, par: PAR_NONE, stop2: 1'b0};
      pv_q   <= 1'b0;
    end else begin
      act_q  <= act_d;
      pend_q <= pend_d;
      pv_q   <= pv_d;
    end
  end

  uart_rt_baud #(.CLK_HZ(CLK_HZ), .DW(DW)) u_baud (
    .clk(clk), .rst_n(rst_i_n), .run(en && !apply), .sel(act_q.baud), .tick(tick)
  );

  uart_rt_tx u_tx (
    .clk(clk), .rst_n(rst_i_n), .en(en), .tick(tick), .hold(pv_q), .cfg(act_q),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .line(tx_o),
    .idle(tx_idle)
  );

  uart_rt_rx u_rx (
    .clk(clk), .rst_n(rst_i_n), .en(en), .tick(tick), .cfg(act_q), .rx_i(rx_i),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .idle(rx_idle),
    .err_parity(err_parity), .err_frame(err_frame)
  );
endmodule

// File: rtl/uart_rt_chk.sv
module uart_rt_chk (
  input logic clk,
  input logic rst_n,
  input logic hf_mode,
  input logic tx_o,
  input logic tx_ready,
  input logic rx_valid,
  input logic rx_ready,
  input logic err_parity,
  input logic err_frame
);
  assert_off_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hf_mode && $past(hf_mode) |-> tx_o && !tx_ready);

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_o);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_o) |-> !tx_ready);

  assert_rx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid);

  assert_par_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity |=> err_parity);

  assert_frm_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame |=> err_frame);
endmodule

bind uart_rt uart_rt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hf_mode(hf_mode), .tx_o(tx_o), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .err_parity(err_parity),
  .err_frame(err_frame)
);

// File: tb/sim_uart_rt.sv
module sim_uart_rt;
  localparam int CLK_P  = 10;
  localparam int CLK_HZ = 7372800;

  // {rate[13:11], parity[10:9], stop2[8], byte[7:0]}
  localparam logic [13:0] VEC [6] = '{
    {3'd6, 2'd0, 1'b0, 8'hA5},
    {3'd5, 2'd1, 1'b0, 8'h3C},
    {3'd4, 2'd2, 1'b1, 8'h81},
    {3'd3, 2'd1, 1'b1, 8'h00},
    {3'd2, 2'd0, 1'b0, 8'hFF},
    {3'd6, 2'd2, 1'b0, 8'h5A}
  };

  logic clk = 1'b0;
  logic rst_n, hf_mode, rx_i, tx_o, tx_valid, tx_ready, rx_valid, rx_ready;
  logic cfg_wr, cfg_stop2, err_parity, err_frame;
  logic [7:0] tx_data, rx_data;
  logic [2:0] cfg_baud;
  logic [1:0] cfg_par;
  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_rt #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .hf_mode(hf_mode), .rx_i(rx_i), .tx_o(tx_o),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .cfg_wr(cfg_wr), .cfg_baud(cfg_baud),
    .cfg_par(cfg_par), .cfg_stop2(cfg_stop2), .err_parity(err_parity),
    .err_frame(err_frame)
  );

  function automatic int bitc(input int sel);
    int r;
    case (sel)
      0: r = 9600;   1: r = 19200;  2: r = 38400; 3: r = 57600;
      4: r = 115200; 5: r = 230400; default: r = 460800;
    endcase
    return CLK_HZ / r;
  endfunction

  function automatic logic pbit(input logic [7:0] b, input int par);
    return (par == 2) ? ~^b : ^b;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_w(input logic [2:0] s, input logic [1:0] p, input logic st2);
    @(negedge clk);
    cfg_baud = s; cfg_par = p; cfg_stop2 = st2; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic get_tx(input int bc, input int par, input bit st2, input logic [7:0] exp, input string req);
    int t = 0;
    logic [7:0] got;
    while (tx_o !== 1'b0 && t < 60000) begin @(negedge clk); t++; end
    chk(t < 60000, req, "frame start seen", t, 0);
    cyc(bc / 2);
    chk(tx_o == 1'b0, req, "start bit low", int'(tx_o), 0);
    for (int i = 0; i < 8; i++) begin cyc(bc); got[i] = tx_o; end
    chk(got == exp, req, "tx data lsb first", int'(got), int'(exp));
    if (par != 0) begin
      cyc(bc);
      chk(tx_o == pbit(exp, par), req, "tx parity bit", int'(tx_o), int'(pbit(exp, par)));
    end
    cyc(bc);
    chk(tx_o == 1'b1 && !tx_ready, req, "stop high and busy", int'({tx_o, tx_ready}), 2);
    if (st2) begin
      cyc(bc);
      chk(tx_o == 1'b1 && !tx_ready, req, "R5 second stop busy", int'({tx_o, tx_ready}), 2);
    end
    cyc(bc);
    chk(tx_ready == 1'b1, req, "ready after stop", int'(tx_ready), 1);
  endtask

  task automatic put_rx(input int bc, input logic [7:0] b, input int par,
                        input bit flip, input bit bad_stop, input bit spike);
    int d = bc / 16;
    rx_i = 1'b0; cyc(bc);
    for (int i = 0; i < 8; i++) begin
      rx_i = b[i];
      if (spike && i == 0) begin
        cyc(bc / 2); rx_i = ~b[i]; cyc(d / 2); rx_i = b[i]; cyc(bc - bc / 2 - d / 2);
      end else cyc(bc);
    end
    if (par != 0) begin rx_i = pbit(b, par) ^ flip; cyc(bc); end
    rx_i = ~bad_stop; cyc(bc);
    rx_i = 1'b1; cyc(2);
  endtask

  task automatic take;
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  initial begin
    #(CLK_P * 195000);
    bad++;
    $display("FAIL watchdog run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hf_mode = 1'b0; rx_i = 1'b1; tx_valid = 1'b0; tx_data = '0;
    rx_ready = 1'b0; cfg_wr = 1'b0; cfg_baud = '0; cfg_par = '0; cfg_stop2 = 1'b0;
    cyc(5); rst_n = 1'b1; cyc(5);

    // R1 reset state and defaults
    chk(tx_o && tx_ready && !rx_valid && !err_parity && !err_frame, "R1", "reset outputs",
        int'({tx_o, tx_ready, rx_valid, err_parity, err_frame}), 5'b11000);
    fork send(8'h96); get_tx(bitc(0), 0, 1'b0, 8'h96, "R1"); join

    // R2 R3 R4 R5 table walk: transmit then receive each format
    foreach (VEC[k]) begin
      cfg_w(VEC[k][13:11], VEC[k][10:9], VEC[k][8]);
      cyc(4);
      fork
        send(VEC[k][7:0]);
        get_tx(bitc(int'(VEC[k][13:11])), int'(VEC[k][10:9]), VEC[k][8], VEC[k][7:0], "R2/R3/R4");
      join
      put_rx(bitc(int'(VEC[k][13:11])), VEC[k][7:0], int'(VEC[k][10:9]), 1'b0, 1'b0, 1'b0);
      chk(rx_valid && rx_data == VEC[k][7:0] && !err_parity && !err_frame, "R3", "rx byte",
          int'(rx_data), int'(VEC[k][7:0]));
      take;
    end

    // R6 rate code 7 rejected, R4 parity code 3 rejected: last format stays
    cfg_w(3'd7, 2'd1, 1'b1);
    cyc(4);
    fork send(8'hC3); get_tx(bitc(6), 2, 1'b0, 8'hC3, "R6"); join
    cfg_w(3'd3, 2'd3, 1'b0);
    cyc(4);
    fork send(8'h17); get_tx(bitc(6), 2, 1'b0, 8'h17, "R4"); join

    // R8 short start pulse dropped, then majority survives a spike
    cfg_w(3'd2, 2'd0, 1'b0);
    cyc(4);
    rx_i = 1'b0; cyc(bitc(2) * 5 / 16); rx_i = 1'b1; cyc(bitc(2) * 12);
    chk(!rx_valid, "R8", "glitch start ignored", int'(rx_valid), 0);
    put_rx(bitc(2), 8'h6E, 0, 1'b0, 1'b0, 1'b1);
    chk(rx_valid && rx_data == 8'h6E, "R8", "spike outvoted", int'(rx_data), 8'h6E);
    // R11 byte held until taken
    cyc(60);
    chk(rx_valid && rx_data == 8'h6E, "R11", "byte held", int'(rx_valid), 1);
    take;
    chk(!rx_valid, "R11", "cleared after take", int'(rx_valid), 0);

    // R9 parity error and framing error are sticky and bytes still arrive
    cfg_w(3'd2, 2'd1, 1'b0);
    cyc(4);
    put_rx(bitc(2), 8'h29, 1, 1'b1, 1'b0, 1'b0);
    chk(rx_valid && rx_data == 8'h29 && err_parity && !err_frame, "R9", "parity error",
        int'({rx_data, err_parity, err_frame}), {8'h29, 2'b10});
    take;
    put_rx(bitc(2), 8'hD4, 1, 1'b0, 1'b1, 1'b0);
    chk(rx_valid && rx_data == 8'hD4 && err_frame, "R9", "framing error",
        int'({rx_data, err_frame}), {8'hD4, 1'b1});
    take;
    put_rx(bitc(2), 8'h0F, 1, 1'b0, 1'b0, 1'b0);
    chk(err_parity && err_frame && rx_data == 8'h0F, "R9", "flags sticky",
        int'({err_parity, err_frame}), 3);
    take;

    // R10 high-frequency clock mode disables the port
    cfg_w(3'd6, 2'd0, 1'b0);
    cyc(4);
    hf_mode = 1'b1; cyc(2);
    chk(tx_o && !tx_ready, "R10", "off: line high, not ready", int'({tx_o, tx_ready}), 2);
    tx_data = 8'h33; tx_valid = 1'b1; cyc(20); tx_valid = 1'b0;
    put_rx(bitc(6), 8'h44, 0, 1'b0, 1'b0, 1'b0);
    chk(!rx_valid && tx_o, "R10", "rx ignored, tx idle", int'({rx_valid, tx_o}), 1);
    hf_mode = 1'b0; cyc(4);
    chk(tx_o && tx_ready && !rx_valid, "R10", "back on idle", int'({tx_o, tx_ready, rx_valid}), 6);

    // R7 write during a slow frame: old frame finishes slow, next one is fast
    cfg_w(3'd2, 2'd0, 1'b0);
    cyc(4);
    fork
      send(8'h4B);
      get_tx(bitc(2), 0, 1'b0, 8'h4B, "R7");
      begin
        cyc(bitc(2) * 3);
        cfg_w(3'd6, 2'd0, 1'b0);
        cyc(1);
        chk(!tx_ready, "R7", "busy while pending", int'(tx_ready), 0);
      end
    join
    fork send(8'hB2); get_tx(bitc(6), 0, 1'b0, 8'hB2, "R7"); join

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule